// File: doc/BRIEF.md
# Bitsection Run-Length Pixel Compressor

This block is a streaming, lossless compressor for 6-bit greyscale pixels. Each pixel is treated as two 3-bit sections, an upper one and a lower one. As pixels arrive, the block looks for two kinds of redundancy. The first is an exact repeat of the whole pixel. The second is a run of pixels in which one section stays fixed while the other changes. A pixel that starts no run leaves the block unchanged as a raw word. A run of two or more pixels is replaced by a flagged control word that carries the run type and its length. For a section run, the control word is followed by raw words that hold the fixed section and the changing sections, packed two per word.

Pixels enter on a valid/ready stream with an end-of-frame marker on the last pixel. Compressed words leave through an internal FIFO with valid/ready flow control. Each word is 6 bits wide and has a side flag that marks it as a control word (1) or a raw word (0). A run never spans a frame boundary. The end-of-frame marker closes the open run, and its words are emitted right away.

Top module: `bsr_pixel_compressor`

## Requirements
- R1: A pixel that shares neither section with the pixel before it in the same open run closes as a single raw word: flag 0, symbol equal to the pixel.
- R2: A run of c (2 to 15) identical pixels becomes a control word with flag 1 and symbol {2'b01, c[3:0]}, followed by one raw word holding the pixel value.
- R3: A run of c pixels with an unchanged upper section (bits 5:3) becomes a control word {2'b10, c}. It is followed by a raw word {upper, lower of first pixel}. Then come raw words {lower[i], lower[i+1]} for i = 1, 3, 5, and so on, with the last word padded with 3'b000 when c-1 is odd.
- R4: A run with an unchanged lower section (bits 2:0) is coded as in R3, with the roles swapped. The control word is {2'b11, c}, the first raw word is {lower, upper of first pixel}, and the following words pack the upper sections.
- R5: When a run starts, an exact pixel repeat takes precedence over a section match. Once a section run is open, a pixel that also repeats the whole previous pixel extends the section run.
- R6: The run length saturates at 15. The 16th matching pixel closes the run and starts a new one.
- R7: The pixel marked end-of-frame is added to the open run, which is then closed and emitted. The first pixel of the next frame starts a fresh run.
- R8: in_ready is low whenever the FIFO has fewer than 2 free entries. Under backpressure no word is lost or duplicated. While out_valid is high and out_ready is low, out_sym and out_cmp hold.
- R9: After a synchronous reset, out_valid is 0 and in_ready is 1.
- R10: Under any out_ready pattern, the words leave in the order of the pixels they describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Compressor can take a pixel |
| in_pix | input | 6 | Pixel value |
| in_eof | input | 1 | Marks the last pixel of a frame |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_sym | output | 6 | Output symbol |
| out_cmp | output | 1 | 1 for a control word, 0 for a raw word |

## Verification
The hardest case to reach from the ports is input stalling on a full FIFO. That needs over sixty words queued behind a consumer that stays idle, while the pixels keep arriving. The stimulus sends eighty pixels that each differ from their neighbour in both sections, so every pixel yields its own word. It holds out_ready low for two hundred cycles and checks that in_ready falls and that the held word stays frozen. It then releases the consumer and requires every word back in order. A second hard case is a section run that fills all fifteen slots, which produces the longest packed sequence. A counting pattern on the lower section reaches it.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [2:0] {
    M_EMPTY,
    M_SINGLE,
    M_WHOLE,
    M_UPPER,
    M_LOWER
  } run_mode_e;

  localparam logic [1:0] TY_WHOLE = 2'b01;
  localparam logic [1:0] TY_UPPER = 2'b10;
  localparam logic [1:0] TY_LOWER = 2'b11;

endpackage

// File: rtl/bsr_run_tracker.sv
module bsr_run_tracker
  import bsr_pkg::*;
#(
  parameter int PIX_W = 6,
  parameter int CNT_W = PIX_W - 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  in_valid,
  input  logic [PIX_W-1:0]                      in_pix,
  input  logic                                  in_eof,
  input  logic                                  space_ok,
  output logic                                  in_ready,
  output logic                                  job_valid,
  output run_mode_e                             job_mode,
  output logic [CNT_W-1:0]                      job_cnt,
  output logic [PIX_W-1:0]                      job_anchor,
  output logic [(1<<CNT_W)-2:0][PIX_W/2-1:0]    job_secs,
  input  logic                                  job_done
);

  localparam int SEC_W   = PIX_W / 2;
  localparam int RUN_MAX = (1 << CNT_W) - 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(RUN_MAX);

  run_mode_e                          mode_q;
  logic [PIX_W-1:0]                   anch_q;
  logic [CNT_W-1:0]                   cnt_q;
  logic [RUN_MAX-1:0][SEC_W-1:0]      secs_q;
  logic                               flush_q;

  logic [SEC_W-1:0] q_hi, q_lo, a_hi, a_lo;
  logic             same_hi, same_lo, room, ext, take;
  run_mode_e        start_mode;

  assign q_hi    = in_pix[PIX_W-1:SEC_W];
  assign q_lo    = in_pix[SEC_W-1:0];
  assign a_hi    = anch_q[PIX_W-1:SEC_W];
  assign a_lo    = anch_q[SEC_W-1:0];
  assign same_hi = (q_hi == a_hi);
  assign same_lo = (q_lo == a_lo);
  assign room    = (cnt_q != CNT_TOP);

  assign in_ready = !job_valid && !flush_q && space_ok;
  assign take     = in_valid && in_ready;

  always_comb begin
    start_mode = M_LOWER;
    if (same_hi && same_lo) start_mode = M_WHOLE;
    else if (same_hi)       start_mode = M_UPPER;
    case (mode_q)
      M_SINGLE: ext = same_hi || same_lo;
      M_WHOLE:  ext = same_hi && same_lo && room;
      M_UPPER:  ext = same_hi && room;
      M_LOWER:  ext = same_lo && room;
      default:  ext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= M_EMPTY;
      anch_q     <= '0;
      cnt_q      <= '0;
      secs_q     <= '0;
      flush_q    <= 1'b0;
      job_valid  <= 1'b0;
      job_mode   <= M_EMPTY;
      job_cnt    <= '0;
      job_anchor <= '0;
      job_secs   <= '0;
    end else begin
      if (job_done) job_valid <= 1'b0;
      if (take) begin
        if (!ext && mode_q != M_EMPTY) begin
          job_valid  <= 1'b1;
          job_mode   <= mode_q;
          job_cnt    <= cnt_q;
          job_anchor <= anch_q;
          job_secs   <= secs_q;
        end
        if (ext) begin
          if (mode_q == M_SINGLE) begin
            mode_q    <= start_mode;
            cnt_q     <= CNT_W'(2);
            secs_q[0] <= same_hi ? a_lo : a_hi;
            secs_q[1] <= same_hi ? q_lo : q_hi;
          end else begin
            cnt_q         <= cnt_q + 1'b1;
            secs_q[cnt_q] <= (mode_q == M_UPPER) ? q_lo : q_hi;
          end
        end else begin
          mode_q <= M_SINGLE;
          anch_q <= in_pix;
          cnt_q  <= CNT_W'(1);
        end
        if (in_eof) flush_q <= 1'b1;
      end else if (flush_q && !job_valid) begin
        if (mode_q != M_EMPTY) begin
          job_valid  <= 1'b1;
          job_mode   <= mode_q;
          job_cnt    <= cnt_q;
          job_anchor <= anch_q;
          job_secs   <= secs_q;
        end
        mode_q  <= M_EMPTY;
        flush_q <= 1'b0;
      end
    end
  end

  AST_RUN_MIN: assert property (@(posedge clk) disable iff (rst)
    (mode_q inside {M_WHOLE, M_UPPER, M_LOWER}) |-> (cnt_q >= CNT_W'(2))); // R2
  AST_SAT_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (take && mode_q == M_WHOLE && same_hi && same_lo && cnt_q == CNT_TOP) |=> job_valid); // R6
  AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (rst)
    (flush_q && !job_valid) |=> !flush_q); // R7

endmodule

// File: rtl/bsr_word_emitter.sv
module bsr_word_emitter
  import bsr_pkg::*;
#(
  parameter int PIX_W = 6,
  parameter int CNT_W = PIX_W - 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  job_valid,
  input  run_mode_e                             job_mode,
  input  logic [CNT_W-1:0]                      job_cnt,
  input  logic [PIX_W-1:0]                      job_anchor,
  input  logic [(1<<CNT_W)-2:0][PIX_W/2-1:0]    job_secs,
  input  logic                                  fifo_full,
  output logic                                  wr_en,
  output logic                                  wr_flag,
  output logic [PIX_W-1:0]                      wr_sym,
  output logic                                  job_done
);

  localparam int SEC_W   = PIX_W / 2;
  localparam int RUN_MAX = (1 << CNT_W) - 1;
  localparam int IDX_W   = CNT_W + 1;

  logic [IDX_W-1:0] k_q, last_k, ia, ib;
  logic [SEC_W-1:0] const_sec, sec_a, sec_b;
  logic [1:0]       ty;

  assign ia = (k_q << 1) - IDX_W'(3);
  assign ib = (k_q << 1) - IDX_W'(2);

  always_comb begin
    sec_a = '0;
    sec_b = '0;
    if (ia < IDX_W'(RUN_MAX)) sec_a = job_secs[ia];
    if (ib < IDX_W'(job_cnt) && ib < IDX_W'(RUN_MAX)) sec_b = job_secs[ib];
    const_sec = (job_mode == M_UPPER) ? job_anchor[PIX_W-1:SEC_W] : job_anchor[SEC_W-1:0];
    case (job_mode)
      M_WHOLE: ty = TY_WHOLE;
      M_UPPER: ty = TY_UPPER;
      default: ty = TY_LOWER;
    endcase
    case (job_mode)
      M_SINGLE: last_k = '0;
      M_WHOLE:  last_k = IDX_W'(1);
      default:  last_k = IDX_W'(1) + IDX_W'(job_cnt >> 1);
    endcase
    wr_flag = 1'b0;
    wr_sym  = job_anchor;
    if (job_mode != M_SINGLE && k_q == '0) begin
      wr_flag = 1'b1;
      wr_sym  = {ty, job_cnt};
    end else if (job_mode == M_UPPER || job_mode == M_LOWER) begin
      if (k_q == IDX_W'(1)) wr_sym = {const_sec, job_secs[0]};
      else                  wr_sym = {sec_a, sec_b};
    end
  end

  assign wr_en    = job_valid && !fifo_full;
  assign job_done = wr_en && (k_q == last_k);

  always_ff @(posedge clk) begin
    if (rst)           k_q <= '0;
    else if (job_done) k_q <= '0;
    else if (wr_en)    k_q <= k_q + 1'b1;
  end

  AST_JOB_STABLE: assert property (@(posedge clk) disable iff (rst)
    (job_valid && !job_done) |=> (job_valid && $stable(job_cnt) && $stable(job_anchor))); // R10

endmodule

// File: rtl/bsr_out_fifo.sv
module bsr_out_fifo #(
  parameter int W     = 7,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  output logic         space_ok,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0]   CNT_LOW  = (AW+1)'(DEPTH - 2);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          rd_en;

  assign full     = (count == CNT_FULL);
  assign space_ok = (count <= CNT_LOW);
  assign rd_en    = (count != '0) && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
    if (rd_en) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + (AW+1)'(wr_en) - (AW+1)'(rd_en);
      if (rd_en)          out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (count < CNT_FULL)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

endmodule

// File: rtl/bsr_pixel_compressor.sv
module bsr_pixel_compressor
  import bsr_pkg::*;
#(
  parameter int PIX_W      = 6,
  parameter int FIFO_DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_eof,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_sym,
  output logic             out_cmp
);

  localparam int CNT_W   = PIX_W - 2;
  localparam int SEC_W   = PIX_W / 2;
  localparam int RUN_MAX = (1 << CNT_W) - 1;

  logic                          job_valid, job_done, space_ok, fifo_full;
  run_mode_e                     job_mode;
  logic [CNT_W-1:0]              job_cnt;
  logic [PIX_W-1:0]              job_anchor;
  logic [RUN_MAX-1:0][SEC_W-1:0] job_secs;
  logic                          wr_en, wr_flag;
  logic [PIX_W-1:0]              wr_sym;

  bsr_run_tracker #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_tracker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix), .in_eof(in_eof),
    .space_ok(space_ok), .in_ready(in_ready), .job_valid(job_valid),
    .job_mode(job_mode), .job_cnt(job_cnt), .job_anchor(job_anchor),
    .job_secs(job_secs), .job_done(job_done)
  );

  bsr_word_emitter #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_emitter (
    .clk(clk), .rst(rst), .job_valid(job_valid), .job_mode(job_mode),
    .job_cnt(job_cnt), .job_anchor(job_anchor), .job_secs(job_secs),
    .fifo_full(fifo_full), .wr_en(wr_en), .wr_flag(wr_flag), .wr_sym(wr_sym),
    .job_done(job_done)
  );

  bsr_out_fifo #(.W(PIX_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data({wr_flag, wr_sym}),
    .full(fifo_full), .space_ok(space_ok), .out_valid(out_valid),
    .out_data({out_cmp, out_sym}), .out_ready(out_ready)
  );

  AST_READY_SPACE: assert property (@(posedge clk) disable iff (rst)
    (!space_ok) |-> (!in_ready)); // R8

endmodule

// File: tb/bsr_pixel_compressor_bench.sv
`timescale 1ns/1ps
module bsr_pixel_compressor_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_eof = 1'b0, out_ready = 1'b0;
  logic [5:0] in_pix = '0;
  logic       in_ready, out_valid, out_cmp;
  logic [5:0] out_sym;

  always #10 clk = ~clk;

  bsr_pixel_compressor u_bsr_pixel_compressor (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_eof(in_eof), .out_valid(out_valid),
    .out_ready(out_ready), .out_sym(out_sym), .out_cmp(out_cmp)
  );

  // stimulus {eof, pixel}, octal
  localparam logic [6:0] TBL_IN [16] = '{
    7'o012, 7'o012, 7'o012, 7'o045, 7'o071, 7'o073, 7'o075, 7'o074,
    7'o024, 7'o134, 7'o105, 7'o005, 7'o105, 7'o063, 7'o061, 7'o161 };
  // expected {flag, symbol}, octal
  localparam logic [6:0] TBL_EXP [16] = '{
    7'o123, 7'o012,                   // R2 R5 whole run of 3
    7'o045,                           // R1 raw
    7'o144, 7'o071, 7'o035, 7'o040,   // R3 upper-held run of 4
    7'o162, 7'o042, 7'o030,           // R4 lower-held run of 2 at eof
    7'o005,                           // R7 one-pixel frame
    7'o122, 7'o005,                   // R7 no merge across frames
    7'o143, 7'o063, 7'o011 };         // R5 section run absorbs whole repeat
  localparam int TBL_REQ [16] = '{2,2,1,3,3,3,3,4,4,4,7,7,7,5,5,5};

  int n_chk = 0, n_err = 0;
  logic [6:0] stim [256];
  logic [6:0] expw [256];
  int         expr [256];
  logic [6:0] got  [256];
  int stim_n, exp_n, got_n, extra;
  bit saw_block, done;

  task automatic chk(input bit ok, input int req, input int act, input int expv, input string what);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic play(input int rmode);
    int sp = 0;
    int cyc = 0;
    bit stalled = 1'b0;
    logic [6:0] held = '0;
    got_n = 0;
    saw_block = 1'b0;
    while ((sp < stim_n || got_n < exp_n) && cyc < 4000) begin
      @(negedge clk);
      in_valid = (sp < stim_n);
      in_pix   = stim[sp][5:0];
      in_eof   = stim[sp][6];
      case (rmode)
        0:       out_ready = 1'b1;
        1:       out_ready = (cyc % 3 != 0);
        default: out_ready = (cyc >= 200);
      endcase
      #1;
      if (stalled) // R8 hold under stall
        chk(out_valid && {out_cmp, out_sym} == held, 8, {out_cmp, out_sym}, held, "held word");
      stalled = out_valid && !out_ready;
      held = {out_cmp, out_sym};
      if (in_valid && !in_ready) saw_block = 1'b1;
      if (in_valid && in_ready) sp++;
      if (out_valid && out_ready && got_n < 256) begin
        got[got_n] = {out_cmp, out_sym};
        got_n++;
      end
      cyc++;
    end
    in_valid = 1'b0;
    in_eof = 1'b0;
    out_ready = 1'b1;
    extra = 0;
    repeat (12) begin
      @(negedge clk);
      #1;
      if (out_valid) extra++;
    end
  endtask

  task automatic compare(input int req_n);
    chk(got_n == exp_n, req_n, got_n, exp_n, "word count");
    chk(extra == 0, req_n, extra, 0, "extra words");
    for (int i = 0; i < exp_n; i++)
      chk(got[i] == expw[i], expr[i], got[i], expw[i], $sformatf("word %0d", i));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    done = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, 9, out_valid, 0, "out_valid after reset"); // R9
    chk(in_ready == 1'b1, 9, in_ready, 1, "in_ready after reset");    // R9

    // table walk, consumer ready two cycles of three (R10)
    stim_n = 16;
    exp_n = 16;
    for (int i = 0; i < 16; i++) begin
      stim[i] = TBL_IN[i];
      expw[i] = TBL_EXP[i];
      expr[i] = TBL_REQ[i];
    end
    play(1);
    compare(10);

    // R6: 17 equal pixels saturate the whole-run count at 15
    stim_n = 17;
    for (int i = 0; i < 17; i++) stim[i] = (i == 16) ? 7'o107 : 7'o007;
    exp_n = 4;
    expw[0] = 7'o137; expw[1] = 7'o007; expw[2] = 7'o122; expw[3] = 7'o007;
    for (int i = 0; i < 4; i++) expr[i] = 6;
    play(0);
    compare(6);

    // R3 R6: upper-held run filling all 15 slots, lower counts 0..7,0..6
    stim_n = 15;
    for (int i = 0; i < 15; i++) stim[i] = {(i == 14), 3'd1, 3'(i % 8)};
    exp_n = 9;
    expw[0] = 7'o157;
    expw[1] = 7'o010;
    for (int j = 0; j < 7; j++) expw[2 + j] = {1'b0, 3'((2*j + 1) % 8), 3'((2*j + 2) % 8)};
    for (int i = 0; i < 9; i++) expr[i] = 3;
    play(0);
    compare(3);

    // R8: 80 raw pixels against a stalled consumer
    stim_n = 80;
    exp_n = 80;
    for (int i = 0; i < 80; i++) begin
      stim[i] = {(i == 79), 3'(i), ~3'(i)};
      expw[i] = {1'b0, 3'(i), ~3'(i)};
      expr[i] = 8;
    end
    play(2);
    chk(saw_block, 8, saw_block, 1, "in_ready dropped on full FIFO"); // R8
    compare(8);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule